// File: doc/BRIEF.md
# Decimal Adjust and Radix Split/Combine Unit

This block corrects an 8-bit accumulator pair after decimal arithmetic. The pair is a high byte H and a low byte L. The unit offers six operations:

- **Unpacked digit adjust after addition**, and the same after subtraction. Each works on one digit per byte.
- **Packed digit adjust after addition**, and the same after subtraction. Each works on two digits in L.
- **Split**, which divides L by a radix. The quotient goes to H and the remainder to L.
- **Combine**, which computes H times the radix plus L, leaves the result in L and clears H.

The four adjusts are plain combinational corrections. Their results are registered, so they complete in one cycle. Split and combine have no fast path. They run as iterative sequences of eight steps: a restoring shift-subtract divider and a shift-add multiplier.

A caller presents an operation with a one-cycle `start` pulse. It then waits for `done`. While an iterative sequence runs, `busy` stays high and further `start` pulses are dropped. All results and flags are held in output registers. A flag that an operation does not define keeps the value it had after the previous operation.

Top module: `dau_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every data and flag output is 0 and `done_o`, `busy_o` and `div_err_o` are 0.
- R2: Op code 0 (unpacked add adjust) applies a fix when L[3:0] > 9 or AF_in is 1. With the fix, H becomes H+1 (mod 256), L becomes {0000, (L+6)[3:0]}, and CF and AF become 1. Without it, H is unchanged, L becomes {0000, L[3:0]}, and CF and AF become 0. SF, ZF and PF keep their previous values.
- R3: Op code 1 (unpacked subtract adjust) uses the same condition as R2. With the fix, H becomes H-1 (mod 256), L becomes {0000, (L-6)[3:0]}, and CF and AF become 1. Without it, L becomes {0000, L[3:0]} and CF and AF become 0. SF, ZF and PF are held.
- R4: Op code 2 (packed add adjust) starts from V = L. If L[3:0] > 9 or AF_in, it adds 06h to V and sets AF to 1; otherwise AF is 0. If the original L > 99h or CF_in, it adds 60h to V and sets CF to 1; otherwise CF is 0. L becomes V mod 256 and H is unchanged.
- R5: Op code 3 (packed subtract adjust) follows R4 with subtraction of 06h and 60h in place of addition.
- R6: Op code 4 (split), with a nonzero radix, gives H = L / radix and L = L mod radix. CF and AF are held.
- R7: Op code 5 (combine) gives L = (H × radix + L) mod 256 and H = 0. CF and AF are held.
- R8: A split with radix 0 completes in one cycle with `div_err_o` high together with `done_o`. H, L and all flags stay unchanged.
- R9: A `start` pulse while `busy_o` is high is ignored. It produces no extra `done_o` and does not change the running result. H and L stay stable while `busy_o` stays high.
- R10: Op codes 6 and 7 complete in one cycle and leave every output register unchanged.
- R11: Op codes 0 to 3, 6 and 7 raise `done_o` in the cycle after the accepted start. Split with a nonzero radix, and combine, raise `busy_o` in that cycle instead. `done_o` and `busy_o` are never high together.
- R12: For op codes 2 to 5 (excluding a split with radix 0), the sign, zero and parity flags are taken from the new L. SF is L[7], ZF is 1 when L is 0, and PF is 1 when L has an even number of set bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request; accepted when not busy |
| op_i | input | 3 | Operation code (0 to 7) |
| h_i | input | 8 | High byte of the accumulator pair |
| l_i | input | 8 | Low byte of the accumulator pair |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming auxiliary-carry flag |
| radix_i | input | 8 | Radix for split and combine |
| h_o | output | 8 | Result high byte |
| l_o | output | 8 | Result low byte |
| cf_o | output | 1 | Carry flag |
| af_o | output | 1 | Auxiliary-carry flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Even-parity flag |
| div_err_o | output | 1 | Split attempted with radix 0 |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Iterative sequence in progress |

## Verification
The assertions assume that operation inputs only matter in the cycle where `start_i` is high and `busy_o` is low. They also assume the radix is sampled at that point, since checks on the split remainder compare against the radix captured at acceptance. The stimulus holds all operands stable around each one-cycle start pulse. It issues a new operation only after the previous `done_o` has been seen. The one exception is a deliberate start pulse during a busy split, which carries different operands to show that it is dropped.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int DAU_W = 8;

  typedef enum logic [2:0] {
    OP_UADD  = 3'd0,
    OP_USUB  = 3'd1,
    OP_PADD  = 3'd2,
    OP_PSUB  = 3'd3,
    OP_SPLIT = 3'd4,
    OP_COMB  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } dau_op_e;

  typedef struct packed {
    logic [DAU_W-1:0] h;
    logic [DAU_W-1:0] l;
    logic             cf;
    logic             af;
    logic             sf;
    logic             zf;
    logic             pf;
  } dau_res_t;

  function automatic logic even_par(input logic [DAU_W-1:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/dau_bcd_adjust.sv
module dau_bcd_adjust
  import dau_pkg::*;
#(
  parameter int DW = DAU_W
) (
  input  dau_op_e        op_i,
  input  logic [DW-1:0]  h_i,
  input  logic [DW-1:0]  l_i,
  input  logic           cf_i,
  input  logic           af_i,
  input  logic           sf_i,
  input  logic           zf_i,
  input  logic           pf_i,
  output dau_res_t       res_o
);
  localparam int            NW      = DW / 2;
  localparam logic [NW-1:0] DIG_MAX = NW'(9);
  localparam logic [NW-1:0] NIB_COR = NW'(6);
  localparam logic [DW-1:0] LO_COR  = DW'(6);
  localparam logic [DW-1:0] HI_COR  = DW'(8'h60);
  localparam logic [DW-1:0] PK_MAX  = DW'(8'h99);

  logic [NW-1:0] lo_nib, nib_up, nib_dn;
  logic          lo_fix, hi_fix;
  logic [DW-1:0] pa_1, pa_2, ps_1, ps_2;

  assign lo_nib = l_i[NW-1:0];
  assign lo_fix = (lo_nib > DIG_MAX) | af_i;
  assign hi_fix = (l_i > PK_MAX) | cf_i;
  assign nib_up = lo_nib + NIB_COR;
  assign nib_dn = lo_nib - NIB_COR;
  assign pa_1   = lo_fix ? (l_i + LO_COR) : l_i;
  assign pa_2   = hi_fix ? (pa_1 + HI_COR) : pa_1;
  assign ps_1   = lo_fix ? (l_i - LO_COR) : l_i;
  assign ps_2   = hi_fix ? (ps_1 - HI_COR) : ps_1;

  always_comb begin
    res_o = '{h: h_i, l: l_i, cf: cf_i, af: af_i, sf: sf_i, zf: zf_i, pf: pf_i};
    unique case (op_i)
      OP_UADD: begin
        res_o.h  = lo_fix ? (h_i + DW'(1)) : h_i;
        res_o.l  = {{(DW-NW){1'b0}}, (lo_fix ? nib_up : lo_nib)};
        res_o.cf = lo_fix;
        res_o.af = lo_fix;
      end
      OP_USUB: begin
        res_o.h  = lo_fix ? (h_i - DW'(1)) : h_i;
        res_o.l  = {{(DW-NW){1'b0}}, (lo_fix ? nib_dn : lo_nib)};
        res_o.cf = lo_fix;
        res_o.af = lo_fix;
      end
      OP_PADD: begin
        res_o.l  = pa_2;
        res_o.cf = hi_fix;
        res_o.af = lo_fix;
        res_o.sf = pa_2[DW-1];
        res_o.zf = (pa_2 == '0);
        res_o.pf = even_par(pa_2);
      end
      OP_PSUB: begin
        res_o.l  = ps_2;
        res_o.cf = hi_fix;
        res_o.af = lo_fix;
        res_o.sf = ps_2[DW-1];
        res_o.zf = (ps_2 == '0);
        res_o.pf = even_par(ps_2);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dau_radix_div.sv
module dau_radix_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [DW:0]   shifted, diff;
  logic          fits;

  assign shifted = {rem_q, quo_q[DW-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign fits    = (shifted >= {1'b0, dvs_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[DW-1:0] : shifted[DW-1:0];
        quo_q <= {quo_q[DW-2:0], fits};
        if (cnt_q == CW'(DW-1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/dau_radix_mul.sv
module dau_radix_mul #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] mplier_i,
  input  logic [DW-1:0] mcand_i,
  input  logic [DW-1:0] addend_i,
  output logic          done_o,
  output logic [DW-1:0] prod_o
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] acc_q, mcand_q, mplier_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        acc_q    <= addend_i;
        mcand_q  <= mcand_i;
        mplier_q <= mplier_i;
        cnt_q    <= '0;
        run_q    <= 1'b1;
      end else if (run_q) begin
        if (mplier_q[0]) acc_q <= acc_q + mcand_q;
        mcand_q  <= {mcand_q[DW-2:0], 1'b0};
        mplier_q <= {1'b0, mplier_q[DW-1:1]};
        if (cnt_q == CW'(DW-1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/dau_top.sv
module dau_top
  import dau_pkg::*;
#(
  parameter int DW = DAU_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] h_i,
  input  logic [DW-1:0] l_i,
  input  logic          cf_i,
  input  logic          af_i,
  input  logic [DW-1:0] radix_i,
  output logic [DW-1:0] h_o,
  output logic [DW-1:0] l_o,
  output logic          cf_o,
  output logic          af_o,
  output logic          sf_o,
  output logic          zf_o,
  output logic          pf_o,
  output logic          div_err_o,
  output logic          done_o,
  output logic          busy_o
);
  dau_op_e       op;
  logic          accept, zero_rdx;
  logic          div_go, mul_go, div_done, mul_done;
  logic [DW-1:0] quo, rem, prod;
  dau_res_t      adj;

  logic [DW-1:0] h_q, l_q;
  logic          cf_q, af_q, sf_q, zf_q, pf_q;
  logic          err_q, done_q, pend_q;

  assign op       = dau_op_e'(op_i);
  assign accept   = start_i & ~pend_q;
  assign zero_rdx = (radix_i == '0);
  assign div_go   = accept & (op == OP_SPLIT) & ~zero_rdx;
  assign mul_go   = accept & (op == OP_COMB);

  dau_bcd_adjust #(.DW(DW)) adj_i (
    .op_i(op), .h_i(h_i), .l_i(l_i), .cf_i(cf_i), .af_i(af_i),
    .sf_i(sf_q), .zf_i(zf_q), .pf_i(pf_q), .res_o(adj)
  );

  dau_radix_div #(.DW(DW)) div_i (
    .clk(clk), .rst(rst), .start_i(div_go), .dividend_i(l_i),
    .divisor_i(radix_i), .done_o(div_done), .quo_o(quo), .rem_o(rem)
  );

  dau_radix_mul #(.DW(DW)) mul_i (
    .clk(clk), .rst(rst), .start_i(mul_go), .mplier_i(h_i),
    .mcand_i(radix_i), .addend_i(l_i), .done_o(mul_done), .prod_o(prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= '0; l_q <= '0;
      cf_q <= 1'b0; af_q <= 1'b0; sf_q <= 1'b0; zf_q <= 1'b0; pf_q <= 1'b0;
      err_q <= 1'b0; done_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        unique case (op)
          OP_UADD, OP_USUB, OP_PADD, OP_PSUB: begin
            h_q <= adj.h; l_q <= adj.l;
            cf_q <= adj.cf; af_q <= adj.af;
            sf_q <= adj.sf; zf_q <= adj.zf; pf_q <= adj.pf;
            done_q <= 1'b1;
          end
          OP_SPLIT: begin
            if (zero_rdx) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              pend_q <= 1'b1;
            end
          end
          OP_COMB: pend_q <= 1'b1;
          default: done_q <= 1'b1;
        endcase
      end
      if (div_done) begin
        h_q <= quo; l_q <= rem;
        sf_q <= rem[DW-1]; zf_q <= (rem == '0); pf_q <= even_par(rem);
        done_q <= 1'b1; pend_q <= 1'b0;
      end
      if (mul_done) begin
        h_q <= '0; l_q <= prod;
        sf_q <= prod[DW-1]; zf_q <= (prod == '0); pf_q <= even_par(prod);
        done_q <= 1'b1; pend_q <= 1'b0;
      end
    end
  end

  assign h_o       = h_q;
  assign l_o       = l_q;
  assign cf_o      = cf_q;
  assign af_o      = af_q;
  assign sf_o      = sf_q;
  assign zf_o      = zf_q;
  assign pf_o      = pf_q;
  assign div_err_o = err_q;
  assign done_o    = done_q;
  assign busy_o    = pend_q;
endmodule

// File: rtl/dau_chk.sv
module dau_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [2:0]    op_i,
  input logic [DW-1:0] radix_i,
  input logic [DW-1:0] h_o,
  input logic [DW-1:0] l_o,
  input logic          cf_o,
  input logic          af_o,
  input logic          div_err_o,
  input logic          done_o,
  input logic          busy_o
);
  logic          acc;
  logic [2:0]    last_op;
  logic [DW-1:0] last_rdx;

  assign acc = start_i & ~busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_op  <= '0;
      last_rdx <= '0;
    end else if (acc) begin
      last_op  <= op_i;
      last_rdx <= radix_i;
    end
  end

  // R11
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R11
  single_lat_chk: assert property (@(posedge clk) disable iff (rst)
    acc && (op_i inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6, 3'd7}) |=> done_o);

  // R11
  multi_busy_chk: assert property (@(posedge clk) disable iff (rst)
    acc && (op_i == 3'd5 || (op_i == 3'd4 && radix_i != '0)) |=> busy_o && !done_o);

  // R8
  div_err_chk: assert property (@(posedge clk) disable iff (rst)
    acc && op_i == 3'd4 && radix_i == '0 |=> done_o && div_err_o && $stable(h_o) && $stable(l_o));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) |-> $stable(h_o) && $stable(l_o));

  // R2
  unpacked_flags_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && last_op[2:1] == 2'b00 |-> (cf_o == af_o) && (l_o[DW-1:DW/2] == '0));

  // R7
  combine_h_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && last_op == 3'd5 |-> h_o == '0);

  // R6
  split_rem_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && last_op == 3'd4 && !div_err_o |-> l_o < last_rdx);

  // R10
  reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
    acc && op_i[2:1] == 2'b11 |=> $stable(h_o) && $stable(l_o) && $stable(cf_o) && $stable(af_o));
endmodule

bind dau_top dau_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .radix_i(radix_i),
  .h_o(h_o), .l_o(l_o), .cf_o(cf_o), .af_o(af_o),
  .div_err_o(div_err_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/dau_top_tb_top.sv
`timescale 1ns/1ps
module dau_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] h_i = '0, l_i = '0, radix_i = '0;
  logic       cf_i = 1'b0, af_i = 1'b0;
  logic [7:0] h_o, l_o;
  logic       cf_o, af_o, sf_o, zf_o, pf_o, div_err_o, done_o, busy_o;

  always #4 clk = ~clk;

  dau_top dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .h_i(h_i), .l_i(l_i),
    .cf_i(cf_i), .af_i(af_i), .radix_i(radix_i), .h_o(h_o), .l_o(l_o),
    .cf_o(cf_o), .af_o(af_o), .sf_o(sf_o), .zf_o(zf_o), .pf_o(pf_o),
    .div_err_o(div_err_o), .done_o(done_o), .busy_o(busy_o)
  );

  typedef struct {
    logic [22:0] v;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;

  logic [7:0] m_h = '0, m_l = '0;
  logic       m_cf = 0, m_af = 0, m_sf = 0, m_zf = 0, m_pf = 0;

  function automatic logic [22:0] pack_out();
    return {h_o, l_o, cf_o, af_o, sf_o, zf_o, pf_o, div_err_o};
  endfunction

  task automatic check(input bit ok, input string req, input logic [22:0] act, input logic [22:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void set_nzp(input logic [7:0] v);
    m_sf = v[7];
    m_zf = (v == 8'h00);
    m_pf = ~^v;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", pack_out(), '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(pack_out() === e.v, e.req, pack_out(), e.v);
      end
    end
  end

  task automatic run_op(input logic [2:0] op, input logic [7:0] h, input logic [7:0] l,
                        input logic cf, input logic af, input logic [7:0] rdx,
                        input string req);
    exp_t e;
    int   v;
    bit   err, multi;
    logic [3:0] lo;
    err = 0;
    lo = l[3:0];
    multi = (op == 3'd5) || (op == 3'd4 && rdx != 0);
    case (op)
      3'd0: begin
        if (lo > 9 || af) begin m_h = h + 8'd1; m_l = {4'h0, 4'(lo + 4'd6)}; m_cf = 1; m_af = 1; end
        else begin m_h = h; m_l = {4'h0, lo}; m_cf = 0; m_af = 0; end
      end
      3'd1: begin
        if (lo > 9 || af) begin m_h = h - 8'd1; m_l = {4'h0, 4'(lo - 4'd6)}; m_cf = 1; m_af = 1; end
        else begin m_h = h; m_l = {4'h0, lo}; m_cf = 0; m_af = 0; end
      end
      3'd2, 3'd3: begin
        v = l;
        m_af = (lo > 9 || af);
        m_cf = (l > 8'h99 || cf);
        if (m_af) v = (op == 3'd2) ? v + 6 : v - 6;
        if (m_cf) v = (op == 3'd2) ? v + 'h60 : v - 'h60;
        m_h = h;
        m_l = 8'(v);
        set_nzp(m_l);
      end
      3'd4: begin
        if (rdx == 0) err = 1;
        else begin m_h = l / rdx; m_l = l % rdx; set_nzp(m_l); end
      end
      3'd5: begin
        v = h * rdx + l;
        m_h = 8'h00;
        m_l = 8'(v);
        set_nzp(m_l);
      end
      default: ;
    endcase
    e.v   = {m_h, m_l, m_cf, m_af, m_sf, m_zf, m_pf, err};
    e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    op_i = op; h_i = h; l_i = l; cf_i = cf; af_i = af; radix_i = rdx;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (multi) check(busy_o === 1'b1 && done_o === 1'b0, "R11 busy after start", {22'd0, busy_o}, 23'd1);
    else check(done_o === 1'b1, "R11 done next cycle", {22'd0, done_o}, 23'd1);
    while (done_o !== 1'b1) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    check(pack_out() === '0 && done_o === 0 && busy_o === 0, "R1 reset", pack_out(), '0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pack_out() === '0 && done_o === 0 && busy_o === 0, "R1 after reset", pack_out(), '0);

    // R2 unpacked add adjust
    run_op(3'd0, 8'h01, 8'h0B, 0, 0, 8'd0, "R2 low digit above 9");
    run_op(3'd0, 8'h04, 8'h35, 0, 0, 8'd0, "R2 no fix clears high nibble");
    run_op(3'd0, 8'h10, 8'h02, 0, 1, 8'd0, "R2 fix by AF");
    run_op(3'd0, 8'h22, 8'h09, 0, 0, 8'd0, "R2 boundary 9");
    run_op(3'd0, 8'hFF, 8'hFF, 0, 0, 8'd0, "R2 H wraps");
    // R3 unpacked subtract adjust
    run_op(3'd1, 8'h05, 8'h0F, 0, 0, 8'd0, "R3 low digit above 9");
    run_op(3'd1, 8'h00, 8'h04, 0, 1, 8'd0, "R3 fix by AF, H wraps");
    run_op(3'd1, 8'h07, 8'hC9, 1, 0, 8'd0, "R3 no fix");
    // R4 packed add adjust, R12 flags
    run_op(3'd2, 8'h33, 8'h9A, 0, 0, 8'd0, "R4 both fixes to zero");
    run_op(3'd2, 8'h00, 8'h45, 0, 0, 8'd0, "R4 no fix");
    run_op(3'd2, 8'h00, 8'h0F, 0, 0, 8'd0, "R4 low fix only");
    run_op(3'd2, 8'h00, 8'h12, 1, 0, 8'd0, "R4 fix by CF");
    // R5 packed subtract adjust, R12 flags
    run_op(3'd3, 8'h00, 8'h9F, 0, 0, 8'd0, "R5 both fixes");
    run_op(3'd3, 8'h00, 8'h3A, 0, 0, 8'd0, "R5 low fix only");
    run_op(3'd3, 8'h00, 8'h20, 1, 0, 8'd0, "R5 fix by CF sign");
    // R6 split, R12 flags
    run_op(3'd4, 8'hAA, 8'd77, 0, 0, 8'd10, "R6 split 77 by 10");
    run_op(3'd4, 8'h00, 8'd255, 0, 0, 8'd10, "R6 split 255 by 10");
    run_op(3'd4, 8'h00, 8'd5, 0, 0, 8'd16, "R6 split below radix");
    run_op(3'd4, 8'h12, 8'd0, 0, 0, 8'd10, "R6 split zero");
    run_op(3'd4, 8'h00, 8'd200, 0, 0, 8'd1, "R6 split radix 1");
    // R8 zero radix
    run_op(3'd4, 8'h00, 8'd50, 0, 0, 8'd0, "R8 zero radix");
    // R7 combine
    run_op(3'd5, 8'd7, 8'd3, 0, 0, 8'd10, "R7 combine 73");
    run_op(3'd5, 8'd25, 8'd5, 0, 0, 8'd10, "R7 combine 255");
    run_op(3'd5, 8'd32, 8'd16, 0, 0, 8'd10, "R7 combine wraps");
    // R10 reserved codes
    run_op(3'd6, 8'h55, 8'hAA, 1, 1, 8'd3, "R10 code 6 no change");
    run_op(3'd7, 8'h66, 8'h99, 1, 0, 8'd3, "R10 code 7 no change");

    // R9 start while busy is ignored
    begin
      exp_t e;
      m_h = 8'd9; m_l = 8'd9; set_nzp(m_l);
      e.v = {m_h, m_l, m_cf, m_af, m_sf, m_zf, m_pf, 1'b0};
      e.req = "R9 split unaffected by extra start";
      exp_q.push_back(e);
      @(negedge clk);
      op_i = 3'd4; l_i = 8'd99; h_i = 8'd0; radix_i = 8'd10; start_i = 1'b1;
      @(negedge clk);
      op_i = 3'd5; h_i = 8'd3; l_i = 8'd1; radix_i = 8'd7;
      @(negedge clk);
      start_i = 1'b0;
      while (done_o !== 1'b1) @(negedge clk);
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0, "R9 no extra result", 23'(exp_q.size()), '0);
      check(h_o === 8'd9 && l_o === 8'd9, "R9 outputs after drop", {7'd0, h_o, l_o}, {7'd0, 8'd9, 8'd9});
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule